// File: doc/BRIEF.md
# Serial Command to Bus Bridge

This block lets a host on a serial link read and write single 32-bit words on a memory-mapped bus. A separate receiver hands it received bytes over a valid/ready byte stream. The block decodes a small fixed command set, collects the address and any write data, and runs one bus transaction. For a read it then hands the returned word back, byte by byte, to a separate transmitter over a second valid/ready byte stream.

Only three byte values mean anything to the parser while it is idle. 0x55 is a link-alignment byte that the block swallows. 0xC0 opens a write and 0x80 opens a read. Every other idle byte is dropped. Multi-byte fields travel most-significant byte first. The bus always sees a word-aligned address. The block stops accepting input while a transaction or a reply is still in progress, so bytes wait at the receiver side rather than being lost.

Top module: `dbg_link_master`

## Requirements
- R1: While reset is asserted and after it is released, bus_req and tx_valid are low. Once reset is released, rx_ready is high and the parser is idle.
- R2: A byte 0x55 accepted while idle starts no bus access and no reply, and the parser stays idle.
- R3: An idle byte other than 0x55, 0xC0 or 0x80 is dropped and the parser stays idle.
- R4: A 0xC0 byte followed by four address bytes and four data bytes produces exactly one bus access with bus_we high.
- R5: A 0x80 byte followed by four address bytes produces exactly one bus access with bus_we low. No data bytes are consumed, so the next byte after the reply is parsed as a fresh command.
- R6: The four address bytes arrive with bits 31:24 first, then 23:16, 15:8 and 7:0 last.
- R7: The four write-data bytes arrive most-significant first and form bus_wdata in that order, even when they hold command byte values.
- R8: bus_addr bits 1:0 are always zero, whatever the last address byte holds.
- R9: bus_req stays high, with bus_addr and bus_wdata stable, until bus_ack is sampled high.
- R10: After a read is acknowledged, the word on bus_rdata at the ack is returned as four tx bytes, bits 31:24 first. Each byte is held on tx_data with tx_valid high until tx_ready accepts it.
- R11: rx_ready is low while bus_req or tx_valid is high.
- R12: The cycle after a write is acknowledged, bus_req is low, tx_valid is low and rx_ready is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is present |
| rx_ready | output | 1 | Block accepts a received byte this cycle |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte is present |
| tx_ready | input | 1 | Transmitter takes the reply byte this cycle |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access completes in this cycle |

## Verification
The assertions assume that bus_ack is only raised while bus_req is high and that bus_rdata is valid in the cycle of the acknowledge. They also assume that bytes on the receive side are taken only in cycles where rx_ready is high. The bench's bus responder drives bus_ack only in answer to a live request and drops it the cycle after, with zero or several wait cycles in between. The byte driver holds each byte until it sees rx_ready high before the edge. The transmit side stalls in a repeating pattern so that held reply bytes are exercised.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_BUS,
    ST_RESP
  } link_state_e;

  localparam logic [7:0] CMD_SYNC  = 8'h55;
  localparam logic [7:0] CMD_WRITE = 8'hC0;
  localparam logic [7:0] CMD_READ  = 8'h80;

endpackage

// File: rtl/dbg_link_shift.sv
// Byte collector: each enabled byte enters the low lane and older bytes move up,
// so the first byte received ends up in the most significant lane.
module dbg_link_shift #(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [BYTE_W-1:0]         byte_in,
  output logic [BYTES*BYTE_W-1:0]   word_out
);

  logic [BYTES-1:0][BYTE_W-1:0] lane_q;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  lane_q[g] <= '0;
        else if (en) lane_q[g] <= byte_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  lane_q[g] <= '0;
        else if (en) lane_q[g] <= lane_q[g-1];
      end
    end
  end

  assign word_out = lane_q;

endmodule

// File: rtl/dbg_link_ser.sv
// Reply serializer: loads a word, presents its top byte, shifts up one byte per accept.
module dbg_link_ser #(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [BYTES*BYTE_W-1:0]   word_in,
  input  logic                      shift,
  output logic [BYTE_W-1:0]         byte_out
);

  logic [BYTES-1:0][BYTE_W-1:0] lane_q;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lane_q[g] <= '0;
        else if (load)  lane_q[g] <= word_in[g*BYTE_W +: BYTE_W];
        else if (shift) lane_q[g] <= '0;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lane_q[g] <= '0;
        else if (load)  lane_q[g] <= word_in[g*BYTE_W +: BYTE_W];
        else if (shift) lane_q[g] <= lane_q[g-1];
      end
    end
  end

  assign byte_out = lane_q[BYTES-1];

endmodule

// File: rtl/dbg_link_fsm.sv
module dbg_link_fsm
  import dbg_link_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int DATA_BYTES = 4,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic              bus_we,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic              addr_en,
  output logic              data_en,
  output logic              rsp_load,
  output logic              rsp_shift
);

  localparam int MAX_BYTES = (ADDR_BYTES > DATA_BYTES) ? ADDR_BYTES : DATA_BYTES;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BYTES - 1);

  link_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rx_valid) begin
          if (rx_data == CMD_WRITE) begin
            state_d = ST_ADDR;
            wr_d    = 1'b1;
            cnt_d   = '0;
          end else if (rx_data == CMD_READ) begin
            state_d = ST_ADDR;
            wr_d    = 1'b0;
            cnt_d   = '0;
          end
        end
      end
      ST_ADDR: begin
        if (rx_valid) begin
          if (cnt_q == ADDR_LAST) begin
            cnt_d   = '0;
            state_d = wr_q ? ST_WDATA : ST_BUS;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_WDATA: begin
        if (rx_valid) begin
          if (cnt_q == DATA_LAST) begin
            cnt_d   = '0;
            state_d = ST_BUS;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_BUS: begin
        if (bus_ack) begin
          cnt_d   = '0;
          state_d = wr_q ? ST_IDLE : ST_RESP;
        end
      end
      ST_RESP: begin
        if (tx_ready) begin
          if (cnt_q == DATA_LAST) begin
            cnt_d   = '0;
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
    end
  end

  assign rx_ready  = (state_q == ST_IDLE) || (state_q == ST_ADDR) || (state_q == ST_WDATA);
  assign bus_req   = (state_q == ST_BUS);
  assign bus_we    = wr_q;
  assign tx_valid  = (state_q == ST_RESP);
  assign addr_en   = (state_q == ST_ADDR)  && rx_valid;
  assign data_en   = (state_q == ST_WDATA) && rx_valid;
  assign rsp_load  = bus_req && bus_ack && !wr_q;
  assign rsp_shift = tx_valid && tx_ready;

  a_r2_sync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && rx_valid && rx_data == CMD_SYNC) |=> (state_q == ST_IDLE && !bus_req && !tx_valid));

  a_r3_unknown_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && rx_valid && rx_data != CMD_WRITE && rx_data != CMD_READ) |=> state_q == ST_IDLE);

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_req);

  a_r12_write_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_we) |=> (rx_ready && !bus_req && !tx_valid));

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && tx_valid));

endmodule

// File: rtl/dbg_link_master.sv
module dbg_link_master
  import dbg_link_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);

  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int DATA_BYTES = DATA_W / BYTE_W;
  localparam int ALIGN_BITS = $clog2(DATA_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);

  // Reset: asserts at once, leaves through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic              addr_en, data_en, rsp_load, rsp_shift;
  logic [ADDR_W-1:0] addr_raw;

  dbg_link_fsm #(
    .ADDR_BYTES (ADDR_BYTES),
    .DATA_BYTES (DATA_BYTES),
    .BYTE_W     (BYTE_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .bus_ack   (bus_ack),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .addr_en   (addr_en),
    .data_en   (data_en),
    .rsp_load  (rsp_load),
    .rsp_shift (rsp_shift)
  );

  dbg_link_shift #(.BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en       (addr_en),
    .byte_in  (rx_data),
    .word_out (addr_raw)
  );

  dbg_link_shift #(.BYTES(DATA_BYTES), .BYTE_W(BYTE_W)) u_wdata (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en       (data_en),
    .byte_in  (rx_data),
    .word_out (bus_wdata)
  );

  dbg_link_ser #(.BYTES(DATA_BYTES), .BYTE_W(BYTE_W)) u_reply (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (rsp_load),
    .word_in  (bus_rdata),
    .shift    (rsp_shift),
    .byte_out (tx_data)
  );

  assign bus_addr = addr_raw & ~ALIGN_MASK;

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_req && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_wdata)));

  a_r10_first_byte: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_req && bus_ack && !bus_we) |=> (tx_valid && tx_data == $past(bus_rdata[DATA_W-1 -: BYTE_W])));

  a_r10_tx_held: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r11_ready_low: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_req || tx_valid) |-> !rx_ready);

endmodule

// File: tb/dbg_link_master_tb.sv
`timescale 1ns/1ps
module dbg_link_master_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready;
  logic        bus_req;
  logic        bus_we;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_ack;

  always #10 clk = ~clk;

  dbg_link_master u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack)
  );

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
  } acc_t;

  acc_t       exp_bus[$];
  logic [7:0] exp_tx[$];
  int n_checks = 0;
  int n_fail   = 0;
  int ack_delay = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: called at a falling edge; holds the byte until accepted
  task automatic send_byte(input logic [7:0] b);
    rx_data  = b;
    rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] addr, input logic [31:0] data);
    acc_t e;
    e.we = 1'b1; e.addr = addr & 32'hFFFF_FFFC; e.wdata = data; e.rdata = '0;
    exp_bus.push_back(e);
    send_byte(8'hC0);
    for (int i = 3; i >= 0; i--) send_byte(addr[i*8 +: 8]);
    for (int i = 3; i >= 0; i--) send_byte(data[i*8 +: 8]);
  endtask

  task automatic do_read(input logic [31:0] addr, input logic [31:0] rdata);
    acc_t e;
    e.we = 1'b0; e.addr = addr & 32'hFFFF_FFFC; e.wdata = '0; e.rdata = rdata;
    exp_bus.push_back(e);
    for (int i = 3; i >= 0; i--) exp_tx.push_back(rdata[i*8 +: 8]);
    send_byte(8'h80);
    for (int i = 3; i >= 0; i--) send_byte(addr[i*8 +: 8]);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      if (exp_bus.size() == 0 && exp_tx.size() == 0 && rx_ready && !bus_req) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  // Bus responder and scoreboard for bus accesses
  initial begin
    acc_t        e;
    int          wait_cnt = 0;
    logic [31:0] held_addr = '0;
    logic        last_we = 1'b0;
    bus_ack   = 1'b0;
    bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        if (last_we) check(rx_ready && !bus_req && !tx_valid, "R12", "idle after write",
                           {29'd0, rx_ready, bus_req, tx_valid}, 32'h4);
      end else if (bus_req) begin
        if (wait_cnt == 0) held_addr = bus_addr;
        else check(bus_addr == held_addr, "R9", "address held during wait", bus_addr, held_addr);
        check(!rx_ready, "R11", "rx_ready during bus wait", {31'd0, rx_ready}, 32'd0);
        if (wait_cnt >= ack_delay) begin
          if (exp_bus.size() == 0) begin
            check(1'b0, "R2", "unexpected bus access", bus_addr, 32'd0);
          end else begin
            e = exp_bus.pop_front();
            check(bus_we == e.we, e.we ? "R4" : "R5", "bus_we", {31'd0, bus_we}, {31'd0, e.we});
            check(bus_addr == e.addr, "R6 R8", "bus_addr", bus_addr, e.addr);
            if (e.we) check(bus_wdata == e.wdata, "R7", "bus_wdata", bus_wdata, e.wdata);
            bus_rdata = e.rdata;
            last_we   = e.we;
          end
          bus_ack  = 1'b1;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // Reply monitor with a stalling transmitter
  initial begin
    logic [7:0] eb;
    int cyc = 0;
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      tx_ready = (cyc % 3) != 1;
      if (tx_valid) begin
        check(!rx_ready, "R11", "rx_ready during reply", {31'd0, rx_ready}, 32'd0);
        if (tx_ready) begin
          if (exp_tx.size() == 0) begin
            check(1'b0, "R10", "unexpected reply byte", {24'd0, tx_data}, 32'd0);
          end else begin
            eb = exp_tx.pop_front();
            check(tx_data == eb, "R10", "reply byte", {24'd0, tx_data}, {24'd0, eb});
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    rx_valid = 1'b0;
    rx_data  = '0;
    repeat (3) @(negedge clk);
    check(!bus_req && !tx_valid, "R1", "outputs in reset", {30'd0, bus_req, tx_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rx_ready && !bus_req && !tx_valid, "R1", "idle after reset",
          {29'd0, rx_ready, bus_req, tx_valid}, 32'h4);

    send_byte(8'h55);
    repeat (5) @(negedge clk);
    check(rx_ready && !bus_req && !tx_valid, "R2", "idle after sync byte",
          {29'd0, rx_ready, bus_req, tx_valid}, 32'h4);

    ack_delay = 0;
    do_write(32'h1234_5678, 32'hDEAD_BEEF);
    wait_idle();

    ack_delay = 2;
    do_read(32'hA5A5_A5A7, 32'hCAFE_F00D);
    wait_idle();

    send_byte(8'h00);
    send_byte(8'hFF);
    send_byte(8'h81);
    repeat (4) @(negedge clk);
    check(rx_ready && !bus_req && !tx_valid, "R3", "idle after unknown bytes",
          {29'd0, rx_ready, bus_req, tx_valid}, 32'h4);

    ack_delay = 0;
    do_write(32'h0000_0003, 32'h0102_0304);
    wait_idle();

    ack_delay = 3;
    send_byte(8'h55);
    do_read(32'h0000_0010, 32'h1122_3344);
    do_write(32'hFFFF_FFFE, 32'h80C0_5500);
    wait_idle();

    ack_delay = 1;
    do_read(32'h8000_0001, 32'h55C0_80AA);
    do_read(32'h0000_00FC, 32'h0000_0001);
    wait_idle();

    check(exp_bus.size() == 0, "R4", "bus accesses outstanding", exp_bus.size(), 32'd0);
    check(exp_tx.size() == 0, "R10", "reply bytes outstanding", exp_tx.size(), 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule